// File: doc/BRIEF.md
# Supply Mode Sequencer for an Offline Power Controller

This block decides, once per clock, which of five operating modes a switching power controller is in: start-up, ramp-up, active, stop or low-consumption. All of its inputs are already-digitised comparator flags. Three of them compare the supply rail with a reset level, a start-up level and a turn-on level. One says the high-voltage input is present. Two say that the two feedback pins are inside their working range. One says the disable pin is held low. Two further inputs carry fault requests from a separate protection timer: a stop request for immediate faults, and a timed-fault request that is held until the recovery interval has passed.

From the mode, the block derives three outputs. The first is a switching enable for the gate driver. The other two select between a low-current and a high-current setting for the start-up charger that feeds the supply rail. The sequencer remembers whether the supply has been through a full power-up since it last fell below the reset level. This history decides where the start-up mode leads next: after a cold power-up it leads to the ramp-up phase, in which timed protections are ignored; after a wake-up from low-consumption it goes straight to active.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low, the mode output reads start-up and `sw_en` is low. The mode codes are start-up 0, ramp-up 1, active 2, stop 3 and low-consumption 4.
- R2: Start-up is left only on a clock edge where the supply is above its turn-on level and both feedback flags are high. Otherwise the mode stays start-up.
- R3: Start-up exits to ramp-up if no low-consumption wake-up has happened since the last reset-level drop. After such a wake-up it exits to active.
- R4: Ramp-up lasts exactly `RAMP_CYCLES` clock cycles and then moves to active, unless it is left earlier under R6.
- R5: The timed-fault request has no effect on the mode during ramp-up. In active it moves the block to low-consumption on the next edge.
- R6: In ramp-up, active or stop, the mode becomes low-consumption on the next edge when the supply is below the start-up level or the disable flag is high.
- R7: A stop request drops `sw_en` in the same cycle during ramp-up or active. In active it moves the mode to stop on the next edge. Stop returns to active on the edge after the request is released.
- R8: `sw_en` is high only in ramp-up or active while no stop request is present.
- R9: Low-consumption moves to start-up only on an edge where the disable flag is low, no timed fault is requested and the supply is above its turn-on level.
- R10: A supply below the reset level forces start-up on the next edge from any mode and keeps it there. It also clears the wake-up history, so the next start-up exit goes to ramp-up.
- R11: In start-up and low-consumption, both charge enables are low while the high-voltage flag is low. Otherwise only `chg_lo_en` is high below the start-up level, only `chg_hi_en` is high between the start-up and turn-on levels, and both are low above turn-on.
- R12: Both charge enables are low in ramp-up, active and stop, whatever the supply flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vcc_gt_rst | input | 1 | Supply above reset level |
| vcc_gt_start | input | 1 | Supply above start-up level |
| vcc_gt_on | input | 1 | Supply above turn-on level |
| hv_ok | input | 1 | High-voltage input above charger start level |
| fb_ok | input | 1 | Primary feedback pin in range |
| opto_ok | input | 1 | Isolated feedback pin in range |
| dis_req | input | 1 | Disable pin pulled low |
| flt_timed | input | 1 | Timed-fault request (held through recovery) |
| flt_stop | input | 1 | Immediate stop request |
| mode_o | output | 3 | Current mode code |
| sw_en | output | 1 | Switching enable |
| chg_lo_en | output | 1 | Low-current charger enable |
| chg_hi_en | output | 1 | High-current charger enable |

## Verification
The mode register drives all of the outputs, so a wrong next-state decision shows up on `mode_o` on the very next edge. In the same cycle it flips the switching enable or the charger selection. A stale or wrongly cleared wake-up history is invisible until the following start-up exit, so the bench sends one exit through a low-consumption wake-up and another through a reset-level drop. A ramp counter that is off by one shows only at the final edge of ramp-up, so the bench samples the mode both one cycle before and exactly at the expected handover to active.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [2:0] {
      MD_START = 3'd0,
      MD_RAMP  = 3'd1,
      MD_RUN   = 3'd2,
      MD_HOLD  = 3'd3,
      MD_SLEEP = 3'd4
   } pmode_e;
endpackage

// File: rtl/pms_ramp_timer.sv
module pms_ramp_timer #(
   parameter int RAMP_CYCLES = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (RAMP_CYCLES > 2) ? $clog2(RAMP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(RAMP_CYCLES - 1);

   if (RAMP_CYCLES < 2) begin : g_bad_len
      $error("pms_ramp_timer: RAMP_CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (!run)  cnt <= '0;
      else if (done)  cnt <= '0;
      else            cnt <= cnt + CW'(1);
   end

   // R4: the count never runs past the programmed length
   assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);
endmodule

// File: rtl/pms_charger.sv
module pms_charger
   import pwr_mode_pkg::*;
(
   input  pmode_e mode,
   input  logic   hv_ok,
   input  logic   vcc_gt_start,
   input  logic   vcc_gt_on,
   output logic   chg_lo_en,
   output logic   chg_hi_en
);
   logic charge_mode;

   assign charge_mode = (mode == MD_START) || (mode == MD_SLEEP);

   always_comb begin
      chg_lo_en = 1'b0;
      chg_hi_en = 1'b0;
      if (charge_mode && hv_ok) begin
         if (!vcc_gt_start)   chg_lo_en = 1'b1;
         else if (!vcc_gt_on) chg_hi_en = 1'b1;
      end
   end
endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   vcc_gt_rst,
   input  logic   vcc_gt_start,
   input  logic   vcc_gt_on,
   input  logic   fb_ok,
   input  logic   opto_ok,
   input  logic   dis_req,
   input  logic   flt_timed,
   input  logic   flt_stop,
   input  logic   ramp_done,
   output pmode_e mode,
   output logic   sw_en
);
   pmode_e mode_nxt;
   logic   warm, warm_nxt;
   logic   sag;

   assign sag = !vcc_gt_start || dis_req;

   always_comb begin
      mode_nxt = mode;
      warm_nxt = warm;
      if (!vcc_gt_rst) begin
         mode_nxt = MD_START;
         warm_nxt = 1'b0;
      end else begin
         case (mode)
            MD_START:
               if (vcc_gt_on && fb_ok && opto_ok)
                  mode_nxt = warm ? MD_RUN : MD_RAMP;
            MD_RAMP:
               if (sag)            mode_nxt = MD_SLEEP;
               else if (ramp_done) mode_nxt = MD_RUN;
            MD_RUN:
               if (sag || flt_timed) mode_nxt = MD_SLEEP;
               else if (flt_stop)    mode_nxt = MD_HOLD;
            MD_HOLD:
               if (sag)            mode_nxt = MD_SLEEP;
               else if (!flt_stop) mode_nxt = MD_RUN;
            MD_SLEEP:
               if (!dis_req && !flt_timed && vcc_gt_on) begin
                  mode_nxt = MD_START;
                  warm_nxt = 1'b1;
               end
            default: mode_nxt = MD_START;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= MD_START;
         warm <= 1'b0;
      end else begin
         mode <= mode_nxt;
         warm <= warm_nxt;
      end
   end

   assign sw_en = ((mode == MD_RAMP) || (mode == MD_RUN)) && !flt_stop;

   // R10: a reset-level drop always lands in start-up
   assert_boot_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !vcc_gt_rst |=> (mode == MD_START));

   // R2: no start-up exit without the turn-on level
   assert_start_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_START && !vcc_gt_on) |=> (mode == MD_START));

   // R6: supply sag or disable while powered goes to low-consumption
   assert_sag_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (vcc_gt_rst && sag && (mode inside {MD_RAMP, MD_RUN, MD_HOLD}))
      |=> (mode == MD_SLEEP));

   // R5: timed faults cannot move the ramp-up phase anywhere but active
   assert_ramp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vcc_gt_rst && !sag && mode == MD_RAMP) |=> (mode inside {MD_RAMP, MD_RUN}));

   // R9: disable or pending timed fault keeps low-consumption
   assert_sleep_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (vcc_gt_rst && mode == MD_SLEEP && (dis_req || flt_timed)) |=> (mode == MD_SLEEP));
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int RAMP_CYCLES = 4096
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       vcc_gt_rst,
   input  logic       vcc_gt_start,
   input  logic       vcc_gt_on,
   input  logic       hv_ok,
   input  logic       fb_ok,
   input  logic       opto_ok,
   input  logic       dis_req,
   input  logic       flt_timed,
   input  logic       flt_stop,
   output logic [2:0] mode_o,
   output logic       sw_en,
   output logic       chg_lo_en,
   output logic       chg_hi_en
);
   pmode_e mode;
   logic   ramp_done;

   pms_ramp_timer #(.RAMP_CYCLES(RAMP_CYCLES)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (mode == MD_RAMP),
      .done  (ramp_done)
   );

   pms_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .vcc_gt_rst   (vcc_gt_rst),
      .vcc_gt_start (vcc_gt_start),
      .vcc_gt_on    (vcc_gt_on),
      .fb_ok        (fb_ok),
      .opto_ok      (opto_ok),
      .dis_req      (dis_req),
      .flt_timed    (flt_timed),
      .flt_stop     (flt_stop),
      .ramp_done    (ramp_done),
      .mode         (mode),
      .sw_en        (sw_en)
   );

   pms_charger u_chg (
      .mode         (mode),
      .hv_ok        (hv_ok),
      .vcc_gt_start (vcc_gt_start),
      .vcc_gt_on    (vcc_gt_on),
      .chg_lo_en    (chg_lo_en),
      .chg_hi_en    (chg_hi_en)
   );

   assign mode_o = mode;

   // R12: the charger never runs while the controller is powered up
   assert_chg_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (chg_lo_en || chg_hi_en) |-> (mode == MD_START || mode == MD_SLEEP));

   // R11: at most one charge level at a time
   assert_chg_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({chg_lo_en, chg_hi_en}));

   // R7: stop mode never switches
   assert_hold_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_HOLD) |-> !sw_en);
endmodule

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
   localparam int N = 8;
   localparam int M_START = 0, M_RAMP = 1, M_RUN = 2, M_HOLD = 3, M_SLEEP = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic vcc_gt_rst, vcc_gt_start, vcc_gt_on, hv_ok, fb_ok, opto_ok;
   logic dis_req, flt_timed, flt_stop;
   logic [2:0] mode_o;
   logic sw_en, chg_lo_en, chg_hi_en;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pwr_mode_seq #(.RAMP_CYCLES(N)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .vcc_gt_rst(vcc_gt_rst), .vcc_gt_start(vcc_gt_start), .vcc_gt_on(vcc_gt_on),
      .hv_ok(hv_ok), .fb_ok(fb_ok), .opto_ok(opto_ok), .dis_req(dis_req),
      .flt_timed(flt_timed), .flt_stop(flt_stop),
      .mode_o(mode_o), .sw_en(sw_en), .chg_lo_en(chg_lo_en), .chg_hi_en(chg_hi_en)
   );

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_chg(input string req, input int lo, input int hi);
      chk(req, int'(chg_lo_en), lo);
      chk(req, int'(chg_hi_en), hi);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) tick();
      chk("R1 mode", int'(mode_o), M_START);
      chk("R1 sw_en", int'(sw_en), 0);
      chk_chg("R11 mid band", 0, 1);
      vcc_gt_start = 1'b0; #1;
      chk_chg("R11 low band", 1, 0);
      hv_ok = 1'b0; #1;
      chk_chg("R11 no hv", 0, 0);
      hv_ok = 1'b1; vcc_gt_start = 1'b1;
      rst_n = 1'b1;
      tick();
      chk("R2 below on", int'(mode_o), M_START);
   endtask

   task automatic t_startup();
      vcc_gt_on = 1'b1; fb_ok = 1'b0; #1;
      chk_chg("R11 above on", 0, 0);
      repeat (2) tick();
      chk("R2 fb out", int'(mode_o), M_START);
      fb_ok = 1'b1; opto_ok = 1'b0;
      tick();
      chk("R2 opto out", int'(mode_o), M_START);
      opto_ok = 1'b1;
      tick();
      chk("R3 cold exit", int'(mode_o), M_RAMP);
   endtask

   task automatic t_ramp();
      flt_timed = 1'b1; vcc_gt_on = 1'b0; #1;
      chk("R8 ramp sw", int'(sw_en), 1);
      chk_chg("R12 ramp chg", 0, 0);
      flt_stop = 1'b1; #1;
      chk("R7 ramp gate", int'(sw_en), 0);
      tick();
      chk("R5 masked", int'(mode_o), M_RAMP);
      flt_stop = 1'b0; flt_timed = 1'b0; vcc_gt_on = 1'b1;
      repeat (N - 2) tick();
      chk("R4 last ramp cycle", int'(mode_o), M_RAMP);
      tick();
      chk("R4 to active", int'(mode_o), M_RUN);
      chk("R8 active sw", int'(sw_en), 1);
   endtask

   task automatic t_hold();
      flt_stop = 1'b1; #1;
      chk("R7 active gate", int'(sw_en), 0);
      tick();
      chk("R7 to stop", int'(mode_o), M_HOLD);
      vcc_gt_on = 1'b0; #1;
      chk_chg("R12 stop chg", 0, 0);
      vcc_gt_on = 1'b1;
      flt_stop = 1'b0;
      tick();
      chk("R7 back active", int'(mode_o), M_RUN);
      chk("R8 resume sw", int'(sw_en), 1);
   endtask

   task automatic t_timed();
      flt_timed = 1'b1;
      tick();
      chk("R5 active fault", int'(mode_o), M_SLEEP);
      chk("R8 sleep sw", int'(sw_en), 0);
      chk_chg("R11 sleep above on", 0, 0);
      vcc_gt_on = 1'b0; #1;
      chk_chg("R11 sleep mid", 0, 1);
      vcc_gt_start = 1'b0; #1;
      chk_chg("R11 sleep low", 1, 0);
      vcc_gt_start = 1'b1; vcc_gt_on = 1'b1;
      tick();
      chk("R9 fault pending", int'(mode_o), M_SLEEP);
      flt_timed = 1'b0; dis_req = 1'b1;
      tick();
      chk("R9 disabled", int'(mode_o), M_SLEEP);
      dis_req = 1'b0;
      tick();
      chk("R9 wake", int'(mode_o), M_START);
      tick();
      chk("R3 warm exit", int'(mode_o), M_RUN);
   endtask

   task automatic t_drop();
      vcc_gt_start = 1'b0; vcc_gt_on = 1'b0;
      tick();
      chk("R6 sag", int'(mode_o), M_SLEEP);
      vcc_gt_start = 1'b1; vcc_gt_on = 1'b1;
      repeat (2) tick();
      chk("R3 warm again", int'(mode_o), M_RUN);
      dis_req = 1'b1;
      tick();
      chk("R6 disable active", int'(mode_o), M_SLEEP);
      dis_req = 1'b0;
      repeat (2) tick();
      flt_stop = 1'b1;
      tick();
      chk("R7 stop again", int'(mode_o), M_HOLD);
      dis_req = 1'b1;
      tick();
      chk("R6 disable stop", int'(mode_o), M_SLEEP);
      dis_req = 1'b0; flt_stop = 1'b0;
      repeat (2) tick();
      chk("R9 recover", int'(mode_o), M_RUN);
   endtask

   task automatic t_rstdrop();
      vcc_gt_rst = 1'b0;
      tick();
      chk("R10 forced", int'(mode_o), M_START);
      tick();
      chk("R10 held", int'(mode_o), M_START);
      vcc_gt_rst = 1'b1;
      tick();
      chk("R10 history cleared", int'(mode_o), M_RAMP);
   endtask

   initial begin
      rst_n = 1'b0;
      vcc_gt_rst = 1'b1; vcc_gt_start = 1'b1; vcc_gt_on = 1'b0;
      hv_ok = 1'b1; fb_ok = 1'b1; opto_ok = 1'b1;
      dis_req = 1'b0; flt_timed = 1'b0; flt_stop = 1'b0;
      t_reset();
      t_startup();
      t_ramp();
      t_hold();
      t_timed();
      t_drop();
      t_rstdrop();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end
endmodule